// File: doc/BRIEF.md
# Multicycle Shared-Memory Integer Core

This block is a small 32-bit integer processor that runs one instruction at a time, with no overlap between instructions. One memory port carries both instruction fetches and data loads and stores. An address selector picks either the program counter or the computed data address for that port. Each instruction moves through a fixed series of control states: fetch, then operand read, then execute. Memory instructions add further states after execute.

The core keeps a program counter, an instruction register and a 32-entry register array. It has one ALU for data and address work. Two dedicated adders form the next sequential address and the branch target, so the ALU is never used for program counter arithmetic. The surrounding system supplies a memory whose read data is valid in the same cycle as the address. The system can restart execution at address 0 at any time by raising `clear_pc` for one or more cycles.

Top module: `uni_core`

## Requirements
- R1: After `rst_n` is released, or at the clock edge after `clear_pc` is sampled high, the core is in its fetch step with address 0 on `mem_addr` and `mem_we` low.
- R2: Register-form instructions (opcode 0, sources in bits 25:21 and 20:16, destination in bits 15:11) compute by function code 0x20/0x21 add, 0x22/0x23 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed less-than and 0x2B unsigned less-than. The less-than results are 1 or 0. Each takes 3 cycles from its fetch to the next fetch.
- R3: Immediate arithmetic instructions write the register in bits 20:16. Opcodes 0x08/0x09 add, 0x0A signed less-than and 0x0B unsigned less-than use the sign-extended 16-bit immediate. Opcodes 0x0C and, 0x0D or and 0x0E xor use the zero-extended immediate. Each takes 3 cycles.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: A load (opcode 0x23) reads the word at base register plus sign-extended offset. It drives that address during the fourth cycle after its fetch, writes the word to the register in bits 20:16, and takes 5 cycles.
- R6: A store (opcode 0x2B) drives `mem_we` for exactly one cycle, the fourth after its fetch. It writes register bits 20:16 to the base plus sign-extended offset, and takes 4 cycles.
- R7: A conditional branch (opcode 0x04 on equal, 0x05 on not equal) compares its two source registers. When taken, it continues at PC+4 plus the sign-extended offset shifted left by 2; otherwise it continues at PC+4. Either way it takes 3 cycles.
- R8: A jump (opcode 0x02) continues at the upper 4 bits of PC+4 joined with bits 25:0 of the instruction shifted left by 2, and takes 3 cycles.
- R9: Any other opcode, and any other function code under opcode 0, writes no register and no memory and continues at PC+4 after 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_pc | input | 1 | Synchronous restart at address 0 |
| mem_addr | output | 32 | Byte address of the shared memory access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | High for a write, low for a read |
| mem_rdata | input | 32 | Read data, valid combinationally for `mem_addr` |

## Verification
Every result has a fixed due cycle, counted from the fetch of the instruction that makes it. A fetch address appears 3 cycles after an arithmetic, branch, jump or ignored instruction. The next fetch comes 4 cycles after a store and 5 after a load. A store's write strobe and address appear in the fourth cycle after its fetch, and a load's data address in the same slot. The bench counts cycles from the last `clear_pc` edge and samples `mem_addr` and `mem_we` at the falling edge of exactly those cycles. Register results are stored to memory by the test program and read from the bench's own memory model once the program has settled in its final self-loop.

// File: rtl/uni_core_pkg.sv
package uni_core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_BNE   = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } seq_state_t;

  typedef enum logic [2:0] {
    AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_XOR, AOP_NOR, AOP_SLT, AOP_SLTU
  } alu_op_t;

  typedef enum logic [2:0] {
    CL_NOP, CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP
  } instr_class_t;

  typedef enum logic [1:0] {
    PCS_SEQ, PCS_BRANCH, PCS_JUMP
  } pc_src_t;

  typedef struct packed {
    instr_class_t cls;
    alu_op_t      aop;
    logic         use_imm;
    logic         zext_imm;
    logic         dst_rd;
    logic         br_on_ne;
  } ctrl_t;

  function automatic logic [XLEN-1:0] f_sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_zext16(input logic [15:0] v);
    return {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_alu(input alu_op_t op,
                                            input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    unique case (op)
      AOP_ADD:  y = a + b;
      AOP_SUB:  y = a - b;
      AOP_AND:  y = a & b;
      AOP_OR:   y = a | b;
      AOP_XOR:  y = a ^ b;
      AOP_NOR:  y = ~(a | b);
      AOP_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      AOP_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
      default:  y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] f_branch_target(input logic [XLEN-1:0] pc_next,
                                                      input logic [15:0] off);
    return pc_next + (f_sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] f_jump_target(input logic [XLEN-1:0] pc_next,
                                                    input logic [25:0] idx);
    return {pc_next[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction

endpackage

// File: rtl/uni_decode.sv
module uni_decode
  import uni_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{cls: CL_NOP, aop: AOP_ADD, use_imm: 1'b0, zext_imm: 1'b0,
             dst_rd: 1'b0, br_on_ne: 1'b0};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.cls    = CL_ALU;
        unique case (funct)
          6'h20, 6'h21: ctrl.aop = AOP_ADD;
          6'h22, 6'h23: ctrl.aop = AOP_SUB;
          6'h24:        ctrl.aop = AOP_AND;
          6'h25:        ctrl.aop = AOP_OR;
          6'h26:        ctrl.aop = AOP_XOR;
          6'h27:        ctrl.aop = AOP_NOR;
          6'h2A:        ctrl.aop = AOP_SLT;
          6'h2B:        ctrl.aop = AOP_SLTU;
          default:      ctrl.cls = CL_NOP;
        endcase
      end
      OPC_ADDI, OPC_ADDIU: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.aop = AOP_ADD;
      end
      OPC_SLTI: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.aop = AOP_SLT;
      end
      OPC_SLTIU: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.aop = AOP_SLTU;
      end
      OPC_ANDI: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.aop = AOP_AND;
      end
      OPC_ORI: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.aop = AOP_OR;
      end
      OPC_XORI: begin
        ctrl.cls = CL_ALU; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.aop = AOP_XOR;
      end
      OPC_LOAD: begin
        ctrl.cls = CL_LOAD; ctrl.use_imm = 1'b1; ctrl.aop = AOP_ADD;
      end
      OPC_STORE: begin
        ctrl.cls = CL_STORE; ctrl.use_imm = 1'b1; ctrl.aop = AOP_ADD;
      end
      OPC_BEQ: begin
        ctrl.cls = CL_BRANCH; ctrl.aop = AOP_SUB;
      end
      OPC_BNE: begin
        ctrl.cls = CL_BRANCH; ctrl.aop = AOP_SUB; ctrl.br_on_ne = 1'b1;
      end
      OPC_JUMP: ctrl.cls = CL_JUMP;
      default:  ctrl.cls = CL_NOP;
    endcase
  end

endmodule

// File: rtl/uni_regfile.sv
module uni_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);

  logic [WIDTH-1:0] regs [NREG];

  // Entry 0 has no write path; it keeps its reset value of zero.
  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_addr == AW'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

  // R4: the zero register reads zero on both ports, even after a write to it
  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  assert_zero_reg_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/uni_seq.sv
module uni_seq
  import uni_core_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_pc,
  input  instr_class_t cls,
  input  logic         br_taken,
  output seq_state_t   state,
  output logic         load_ir,
  output logic         load_ops,
  output logic         load_addr,
  output logic         load_mdr,
  output logic         mem_we,
  output logic         rf_we,
  output logic         wb_from_mem,
  output logic         pc_we,
  output pc_src_t      pc_src,
  output logic         addr_from_alu
);

  seq_state_t nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_FETCH;
    else if (clear_pc) state <= ST_FETCH;
    else               state <= nxt;
  end

  always_comb begin
    nxt           = ST_FETCH;
    load_ir       = 1'b0;
    load_ops      = 1'b0;
    load_addr     = 1'b0;
    load_mdr      = 1'b0;
    mem_we        = 1'b0;
    rf_we         = 1'b0;
    wb_from_mem   = 1'b0;
    pc_we         = 1'b0;
    pc_src        = PCS_SEQ;
    addr_from_alu = 1'b0;
    unique case (state)
      ST_FETCH: begin
        load_ir = 1'b1;
        nxt     = ST_DECODE;
      end
      ST_DECODE: begin
        load_ops = 1'b1;
        nxt      = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (cls)
          CL_LOAD, CL_STORE: begin
            load_addr = 1'b1;
            nxt       = ST_MEM;
          end
          CL_ALU: begin
            rf_we = 1'b1;
            pc_we = 1'b1;
          end
          CL_BRANCH: begin
            pc_we  = 1'b1;
            pc_src = br_taken ? PCS_BRANCH : PCS_SEQ;
          end
          CL_JUMP: begin
            pc_we  = 1'b1;
            pc_src = PCS_JUMP;
          end
          default: pc_we = 1'b1;
        endcase
      end
      ST_MEM: begin
        addr_from_alu = 1'b1;
        if (cls == CL_LOAD) begin
          load_mdr = 1'b1;
          nxt      = ST_WB;
        end else begin
          mem_we = 1'b1;
          pc_we  = 1'b1;
        end
      end
      ST_WB: begin
        rf_we       = 1'b1;
        wb_from_mem = 1'b1;
        pc_we       = 1'b1;
      end
      default: nxt = ST_FETCH;
    endcase
  end

  // R1: a restart always lands in the fetch step
  assert_restart_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pc |=> (state == ST_FETCH));

  // R6: the write strobe lasts one cycle and the next cycle is a fetch
  assert_store_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && state == ST_FETCH));

  // R5: write-back only follows the memory step of a load
  assert_load_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mdr && !clear_pc) |=> (state == ST_WB));

endmodule

// File: rtl/uni_core.sv
module uni_core
  import uni_core_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_pc,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata
);

  logic [XLEN-1:0] pc_q, ir_q, opa_q, opb_q, addr_q, mdr_q;

  ctrl_t        ctrl;
  seq_state_t   state;
  pc_src_t      pc_src;
  logic         load_ir, load_ops, load_addr, load_mdr;
  logic         rf_we, wb_from_mem, pc_we, addr_from_alu;
  logic         br_taken;

  logic [XLEN-1:0] rf_a, rf_b, imm_ext, alu_b, alu_y, rf_wdata;
  logic [XLEN-1:0] pc_plus4, br_target, jmp_target, pc_next;
  logic [RAW-1:0]  rf_waddr;
  logic            alu_zero;
  logic            exec_branch_fall;

  uni_decode u_decode (
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .ctrl   (ctrl)
  );

  uni_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_pc      (clear_pc),
    .cls           (ctrl.cls),
    .br_taken      (br_taken),
    .state         (state),
    .load_ir       (load_ir),
    .load_ops      (load_ops),
    .load_addr     (load_addr),
    .load_mdr      (load_mdr),
    .mem_we        (mem_we),
    .rf_we         (rf_we),
    .wb_from_mem   (wb_from_mem),
    .pc_we         (pc_we),
    .pc_src        (pc_src),
    .addr_from_alu (addr_from_alu)
  );

  uni_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (ir_q[21+RAW-1:21]),
    .rd_addr_b (ir_q[16+RAW-1:16]),
    .rd_data_a (rf_a),
    .rd_data_b (rf_b),
    .wr_en     (rf_we),
    .wr_addr   (rf_waddr),
    .wr_data   (rf_wdata)
  );

  // Operand selection and the ALU
  assign imm_ext  = ctrl.zext_imm ? f_zext16(ir_q[15:0]) : f_sext16(ir_q[15:0]);
  assign alu_b    = ctrl.use_imm ? imm_ext : opb_q;
  assign alu_y    = f_alu(ctrl.aop, opa_q, alu_b);
  assign alu_zero = (alu_y == '0);
  assign br_taken = (ctrl.cls == CL_BRANCH) && (alu_zero ^ ctrl.br_on_ne);

  // Register write path
  assign rf_waddr = ctrl.dst_rd ? ir_q[11+RAW-1:11] : ir_q[16+RAW-1:16];
  assign rf_wdata = wb_from_mem ? mdr_q : alu_y;

  // Dedicated program counter adders
  assign pc_plus4   = pc_q + XLEN'(4);
  assign br_target  = f_branch_target(pc_plus4, ir_q[15:0]);
  assign jmp_target = f_jump_target(pc_plus4, ir_q[25:0]);

  always_comb begin
    unique case (pc_src)
      PCS_BRANCH: pc_next = br_target;
      PCS_JUMP:   pc_next = jmp_target;
      default:    pc_next = pc_plus4;
    endcase
  end

  // Shared memory port
  assign mem_addr  = addr_from_alu ? addr_q : pc_q;
  assign mem_wdata = opb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ir_q   <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      addr_q <= '0;
      mdr_q  <= '0;
    end else if (clear_pc) begin
      pc_q <= '0;
    end else begin
      if (pc_we)     pc_q   <= pc_next;
      if (load_ir)   ir_q   <= mem_rdata;
      if (load_ops)  opa_q  <= rf_a;
      if (load_ops)  opb_q  <= rf_b;
      if (load_addr) addr_q <= alu_y;
      if (load_mdr)  mdr_q  <= mem_rdata;
    end
  end

  assign exec_branch_fall = (state == ST_EXEC) && (ctrl.cls == CL_BRANCH) && !br_taken;

  // R1: a restart puts the program counter back at zero
  assert_restart_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pc |=> (pc_q == '0));

  // R7: an untaken branch moves on by exactly one word
  assert_branch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_branch_fall && !clear_pc) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R9: an ignored instruction neither writes memory nor the register array
  assert_ignored_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ctrl.cls == CL_NOP) |-> (!rf_we && !mem_we));

endmodule

// File: tb/uni_core_bench.sv
module uni_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear_pc;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [31:0] mem [256];
  logic        ld_en, clr_all;
  logic [7:0]  ld_idx;
  logic [31:0] ld_dat;
  int          cyc;
  int          n_chk, n_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  uni_core u_uni_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_pc  (clear_pc),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (clr_all) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
    end else if (ld_en) begin
      mem[ld_idx] <= ld_dat;
    end else if (mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (clear_pc) cyc <= 0;
    else          cyc <= cyc + 1;
  end

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [31:0] target);
    return {6'h02, target[27:2]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = a[9:2]; ld_dat = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    clear_pc = 1'b1;
    clr_all  = 1'b1;
    @(negedge clk);
    clr_all  = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    clear_pc = 1'b0;
  endtask

  task automatic at(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 fetch address after reset", mem_addr, 32'h0);
    chk("R1 no write after reset", {31'h0, mem_we}, 32'h0);
    // zero words are ignored instructions: next fetch 3 cycles later
    repeat (3) @(negedge clk);
    chk("R9 zero word advances by 4", mem_addr, 32'h4);
  endtask

  task automatic t_reg_ops();
    logic [31:0] a, b;
    a = 32'd5; b = 32'hFFFF_FFFD;
    begin_prog();
    put(32'h00, enc_i(6'h09, 5'd0, 5'd1, 16'h0005));
    put(32'h04, enc_i(6'h09, 5'd0, 5'd2, 16'hFFFD));
    put(32'h08, enc_r(5'd1, 5'd2, 5'd3, 6'h20));
    put(32'h0C, enc_r(5'd1, 5'd2, 5'd4, 6'h22));
    put(32'h10, enc_r(5'd1, 5'd2, 5'd5, 6'h24));
    put(32'h14, enc_r(5'd1, 5'd2, 5'd6, 6'h25));
    put(32'h18, enc_r(5'd1, 5'd2, 5'd7, 6'h26));
    put(32'h1C, enc_r(5'd1, 5'd2, 5'd8, 6'h27));
    put(32'h20, enc_r(5'd2, 5'd1, 5'd9, 6'h2A));
    put(32'h24, enc_r(5'd2, 5'd1, 5'd10, 6'h2B));
    put(32'h28, enc_r(5'd1, 5'd1, 5'd0, 6'h21));
    for (int k = 0; k < 9; k++)
      put(32'h2C + 4*k, enc_i(6'h2B, 5'd0, (k == 8) ? 5'd0 : 5'(k + 3), 16'(32'h200 + 4*k)));
    put(32'h50, enc_j(32'h50));
    go();
    at(3);
    chk("R2 register op fetch spacing", mem_addr, 32'h4);
    at(9);
    chk("R2 register op fetch spacing", mem_addr, 32'hC);
    at(160);
    chk("R2 add",   mem[128], a + b);
    chk("R2 sub",   mem[129], a - b);
    chk("R2 and",   mem[130], a & b);
    chk("R2 or",    mem[131], a | b);
    chk("R2 xor",   mem[132], a ^ b);
    chk("R2 nor",   mem[133], ~(a | b));
    chk("R2 signed less-than", mem[134], 32'd1);
    chk("R2 unsigned less-than", mem[135], 32'd0);
    chk("R4 zero register ignores write", mem[136], 32'd0);
  endtask

  task automatic t_imm_ops();
    logic [31:0] s;
    s = 32'hFFFF_8001;
    begin_prog();
    put(32'h00, enc_i(6'h09, 5'd0, 5'd1, 16'h8001));
    put(32'h04, enc_i(6'h0C, 5'd1, 5'd2, 16'hF00F));
    put(32'h08, enc_i(6'h0D, 5'd0, 5'd3, 16'h8000));
    put(32'h0C, enc_i(6'h0E, 5'd1, 5'd4, 16'hFFFF));
    put(32'h10, enc_i(6'h0A, 5'd1, 5'd5, 16'h0001));
    put(32'h14, enc_i(6'h0B, 5'd0, 5'd6, 16'hFFFF));
    put(32'h18, enc_i(6'h08, 5'd1, 5'd7, 16'hFFFF));
    for (int k = 0; k < 7; k++)
      put(32'h1C + 4*k, enc_i(6'h2B, 5'd0, 5'(k + 1), 16'(32'h200 + 4*k)));
    put(32'h38, enc_j(32'h38));
    go();
    at(120);
    chk("R3 add immediate sign-extends", mem[128], s);
    chk("R3 and immediate zero-extends", mem[129], s & 32'h0000_F00F);
    chk("R3 or immediate zero-extends",  mem[130], 32'h0000_8000);
    chk("R3 xor immediate zero-extends", mem[131], s ^ 32'h0000_FFFF);
    chk("R3 signed less-than immediate", mem[132], 32'd1);
    chk("R3 unsigned less-than immediate", mem[133], 32'd1);
    chk("R3 add negative immediate", mem[134], s - 32'd1);
  endtask

  task automatic t_load_store();
    begin_prog();
    put(32'h300, 32'hCAFE_F00D);
    put(32'h318, 32'hFFFF_FFFF);
    put(32'h00, enc_i(6'h09, 5'd0, 5'd1, 16'h0304));
    put(32'h04, enc_i(6'h23, 5'd1, 5'd2, 16'hFFFC));
    put(32'h08, enc_i(6'h2B, 5'd1, 5'd2, 16'h0010));
    put(32'h0C, enc_i(6'h23, 5'd1, 5'd0, 16'hFFFC));
    put(32'h10, enc_i(6'h2B, 5'd1, 5'd0, 16'h0014));
    put(32'h14, enc_j(32'h14));
    go();
    at(6);
    chk("R5 load address with negative offset", mem_addr, 32'h300);
    at(8);
    chk("R5 load takes 5 cycles", mem_addr, 32'h8);
    at(10);
    chk("R6 no write before memory step", {31'h0, mem_we}, 32'h0);
    at(11);
    chk("R6 write strobe in fourth cycle", {31'h0, mem_we}, 32'h1);
    chk("R6 store address", mem_addr, 32'h314);
    at(12);
    chk("R6 strobe lasts one cycle", {31'h0, mem_we}, 32'h0);
    chk("R6 store takes 4 cycles", mem_addr, 32'hC);
    at(60);
    chk("R5 loaded word stored back", mem[197], 32'hCAFE_F00D);
    chk("R4 load into zero register discarded", mem[198], 32'h0);
  endtask

  task automatic t_branch_jump();
    begin_prog();
    put(32'h00, enc_i(6'h09, 5'd0, 5'd3, 16'h0055));
    put(32'h04, enc_i(6'h09, 5'd0, 5'd1, 16'h0007));
    put(32'h08, enc_i(6'h09, 5'd0, 5'd2, 16'h0007));
    put(32'h0C, enc_i(6'h04, 5'd1, 5'd2, 16'h0002));
    put(32'h10, enc_i(6'h09, 5'd0, 5'd3, 16'h0011));
    put(32'h14, enc_i(6'h09, 5'd0, 5'd3, 16'h0022));
    put(32'h18, enc_i(6'h05, 5'd1, 5'd2, 16'h0003));
    put(32'h1C, enc_i(6'h09, 5'd0, 5'd4, 16'h0033));
    put(32'h20, enc_i(6'h04, 5'd1, 5'd0, 16'h0005));
    put(32'h24, enc_i(6'h05, 5'd4, 5'd0, 16'h0002));
    put(32'h28, enc_i(6'h09, 5'd0, 5'd4, 16'h0099));
    put(32'h2C, enc_i(6'h09, 5'd0, 5'd4, 16'h0099));
    put(32'h30, enc_i(6'h2B, 5'd0, 5'd3, 16'h0200));
    put(32'h34, enc_i(6'h2B, 5'd0, 5'd4, 16'h0204));
    put(32'h38, enc_j(32'h40));
    put(32'h3C, enc_j(32'h3C));
    put(32'h40, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFE));
    go();
    at(12);
    chk("R7 taken equal branch target", mem_addr, 32'h18);
    at(15);
    chk("R7 untaken not-equal branch", mem_addr, 32'h1C);
    at(21);
    chk("R7 untaken equal branch", mem_addr, 32'h24);
    at(24);
    chk("R7 taken not-equal branch", mem_addr, 32'h30);
    at(35);
    chk("R8 jump target", mem_addr, 32'h40);
    at(38);
    chk("R7 backward branch target", mem_addr, 32'h3C);
    at(50);
    chk("R8 jump to itself", mem_addr, 32'h3C);
    chk("R7 skipped writes did not happen", mem[128], 32'h55);
    chk("R7 fall-through write happened", mem[129], 32'h33);
  endtask

  task automatic t_ignored();
    begin_prog();
    put(32'h00, enc_i(6'h09, 5'd0, 5'd5, 16'h0077));
    put(32'h04, enc_i(6'h3F, 5'd0, 5'd5, 16'h1234));
    put(32'h08, enc_r(5'd5, 5'd5, 5'd5, 6'h00));
    put(32'h0C, enc_i(6'h2B, 5'd0, 5'd5, 16'h0200));
    put(32'h10, enc_j(32'h10));
    go();
    at(4);
    chk("R9 ignored opcode no write strobe", {31'h0, mem_we}, 32'h0);
    at(6);
    chk("R9 ignored opcode advances by 4", mem_addr, 32'h8);
    at(9);
    chk("R9 ignored function advances by 4", mem_addr, 32'hC);
    at(40);
    chk("R9 register left untouched", mem[128], 32'h77);
  endtask

  initial begin
    rst_n = 1'b0; clear_pc = 1'b0; ld_en = 1'b0; clr_all = 1'b1;
    ld_idx = '0; ld_dat = '0; n_chk = 0; n_fail = 0;
    repeat (2) @(negedge clk);
    clr_all = 1'b0;
    fork
      begin
        t_reset();
        t_reg_ops();
        t_imm_ops();
        t_load_store();
        t_branch_jump();
        t_ignored();
      end
      begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual=%0d cycles expected<%0d", WD_CYCLES, WD_CYCLES);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule